// File: doc/BRIEF.md
# GPIO pin bank controller with edge capture

This block controls a bank of general-purpose pins (64 or 96) through a small 32-bit register bus. Software reads the synchronized pin levels, chooses per pin whether the block drives it, sets or clears output values with write-one strobes, and picks which transitions on each pin are recorded. Recorded transitions stay latched until software writes ones over them. A single level-high interrupt line is asserted while any latched transition remains.

Registers are grouped by feature, and each feature spans NUM_PINS/32 consecutive words. The feature groups appear in this order: level, direction, set, clear, rising enable, falling enable, status. Every pin input passes through a two-stage synchronizer before it is read or compared against its previous value.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, pin_oe and pin_out are all zero, irq is low, and every mapped word reads 0 while the pin inputs are held low.
- R2: A word's byte address is feature*(NUM_PINS/32)*4 + word*4, with features level=0, direction=1, set=2, clear=3, rising=4, falling=5, status=6. Pin p sits in word p/32 at bit p%32. Addresses past the map or with nonzero low two bits read 0, and writes to them change nothing.
- R3: The level words return the synchronized pin inputs. A change made before clock edge E1 is seen by a read sampled at edge E3 but not by one sampled at E2. Writes to the level words have no effect.
- R4: A direction bit of 1 drives pin_oe high for that pin and 0 leaves it as an input. The direction words read back as written.
- R5: Writing 1 to a bit of a set word drives that pin_out bit to 1. Writing 1 to a bit of a clear word drives it to 0. Zero bits leave the output unchanged. Set and clear words read 0.
- R6: pin_out and pin_oe change only in the cycle after a bus write.
- R7: A 0-to-1 synchronized transition latches the pin's status bit when its rising enable is 1, and a 1-to-0 transition latches it when its falling enable is 1. With both enables set, either transition latches. With neither set, nothing latches.
- R8: A status bit stays set until a 1 is written to it. Writing 0 leaves it unchanged.
- R9: If an enabled transition is detected in the same cycle that software writes 1 to that status bit, the bit stays set.
- R10: irq is high exactly while any status bit is set. It rises at edge E3 after a pin change that precedes edge E1.
- R11: bus_rdata loads the addressed word at the edge where bus_rd is sampled high, and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| irq | output | 1 | Level-high interrupt, OR of status |

## Verification
A wrong direction or output register appears at pin_oe or pin_out in the cycle right after the faulty write. A broken address decode shows up on the next readback as a word written into the wrong feature or the wrong lane. A faulty synchronizer or previous-value register moves the moment irq rises, or makes it rise with no enable set, within three edges of the pin change. A bad clear path leaves irq high after a write of ones, or drops it after a write of zeros, in the next cycle. This cycle-exact timing is checked, along with the clear that collides with a new transition.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int WORD_W   = 32;
   localparam int NUM_FEAT = 7;

   // Order defines the address map: feature index selects the word group.
   typedef enum logic [2:0] {
      FEAT_LEVEL = 3'd0,
      FEAT_DIR   = 3'd1,
      FEAT_SET   = 3'd2,
      FEAT_CLR   = 3'd3,
      FEAT_RISE  = 3'd4,
      FEAT_FALL  = 3'd5,
      FEAT_STAT  = 3'd6
   } feat_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int WIDTH  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pinbank_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
   import pinbank_pkg::*;
#(
   parameter int WORDS  = 2,
   parameter int ADDR_W = 8,
   localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output feat_e             feat,
   output logic [WIDX_W-1:0] widx,
   output logic              hit
);
   int word_num;

   always_comb begin
      word_num = int'(addr[ADDR_W-1:2]);
      hit      = (addr[1:0] == 2'b00) && (word_num < NUM_FEAT * WORDS);
      if (hit) begin
         feat = feat_e'(3'(word_num / WORDS));
         widx = WIDX_W'(word_num % WORDS);
      end else begin
         feat = FEAT_LEVEL;
         widx = '0;
      end
   end
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status,
   output logic             irq
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] detect;

   assign detect = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= lvl;
         // a fresh detection wins over a same-cycle clear
         status <= (status & ~clr_mask) | detect;
      end
   end

   assign irq = |status;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int WORDS    = NUM_PINS / WORD_W;
   localparam int WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int MAP_SIZE = NUM_FEAT * WORDS * 4;

   generate
      if (!(NUM_PINS == 64 || NUM_PINS == 96)) begin : g_bad_pins
         $error("pinbank_ctrl supports 64 or 96 pins only");
      end
      if (MAP_SIZE > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   feat_e             feat;
   logic [WIDX_W-1:0] widx;
   logic              hit;
   logic [NUM_PINS-1:0] lvl;
   logic [NUM_PINS-1:0] dir_q, out_q, rise_q, fall_q;
   logic [NUM_PINS-1:0] clr_mask, status;
   logic [31:0]         rd_mux;

   pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl)
   );

   pinbank_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .feat(feat), .widx(widx), .hit(hit)
   );

   pinbank_edge #(.WIDTH(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_en(rise_q),
      .fall_en(fall_q), .clr_mask(clr_mask), .status(status), .irq(irq)
   );

   function automatic logic [31:0] pick(input logic [NUM_PINS-1:0] v,
                                        input logic [WIDX_W-1:0]   w);
      return v[int'(w)*WORD_W +: WORD_W];
   endfunction

   // register writes, one word lane at a time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (bus_wr && hit) begin
         for (int w = 0; w < WORDS; w++) begin
            if (int'(widx) == w) begin
               case (feat)
                  FEAT_DIR:  dir_q[w*WORD_W +: WORD_W]  <= bus_wdata;
                  FEAT_SET:  out_q[w*WORD_W +: WORD_W]  <= out_q[w*WORD_W +: WORD_W] | bus_wdata;
                  FEAT_CLR:  out_q[w*WORD_W +: WORD_W]  <= out_q[w*WORD_W +: WORD_W] & ~bus_wdata;
                  FEAT_RISE: rise_q[w*WORD_W +: WORD_W] <= bus_wdata;
                  FEAT_FALL: fall_q[w*WORD_W +: WORD_W] <= bus_wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      clr_mask = '0;
      if (bus_wr && hit && feat == FEAT_STAT)
         clr_mask[int'(widx)*WORD_W +: WORD_W] = bus_wdata;
   end

   always_comb begin
      rd_mux = '0;
      if (hit) begin
         case (feat)
            FEAT_LEVEL: rd_mux = pick(lvl, widx);
            FEAT_DIR:   rd_mux = pick(dir_q, widx);
            FEAT_RISE:  rd_mux = pick(rise_q, widx);
            FEAT_FALL:  rd_mux = pick(fall_q, widx);
            FEAT_STAT:  rd_mux = pick(status, widx);
            default:    rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
   parameter int NUM_PINS = 64,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq
);
   localparam int WORDS = NUM_PINS / 32;
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(1 * WORDS * 4);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * WORDS * 4);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(3 * WORDS * 4);

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == SET_A |=> (($past(bus_wdata) & ~pin_out[31:0]) == 32'd0)); // R5
   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == CLR_A |=> (($past(bus_wdata) & pin_out[31:0]) == 32'd0)); // R5
   AST_DIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == DIR_A |=> pin_oe[31:0] == $past(bus_wdata)); // R4
   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_out)); // R6
   AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_oe)); // R6
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !bus_wr |=> irq); // R8
endmodule

bind pinbank_ctrl pinbank_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;
   localparam int AW = 8;
   localparam int WORDS = NP / 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic irq;

   int n_cmp = 0, n_bad = 0;
   logic [NP-1:0] exp_out = '0, exp_oe = '0;
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   pinbank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_pinbank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   function automatic int adr(input int feat, input int w);
      return feat * WORDS * 4 + w * 4;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = AW'(a);
      @(posedge clk); #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe", pin_oe, '0);
      chk("R1 out", pin_out, '0);
      chk("R1 irq", 64'(irq), 0);
      for (int f = 0; f < 7; f++)
         for (int w = 0; w < WORDS; w++) begin
            rd(adr(f, w), rv);
            chk("R1 R2 reset word", 64'(rv), 0);
         end

      // R4 direction, R2 lane placement
      wr(adr(1, 0), 32'hA5A5_0F0F);
      wr(adr(1, 1), 32'h1234_5678);
      exp_oe = 64'h1234_5678_A5A5_0F0F;
      chk("R4 pin_oe", pin_oe, exp_oe);
      rd(adr(1, 0), rv); chk("R4 readback w0", 64'(rv), 64'hA5A5_0F0F);
      rd(adr(1, 1), rv); chk("R4 readback w1", 64'(rv), 64'h1234_5678);

      // R5 set sweep over every pin
      for (int p = 0; p < NP; p++) begin
         wr(adr(2, p / 32), 32'(1) << (p % 32));
         exp_out[p] = 1'b1;
         chk("R5 set sweep", pin_out, exp_out);
      end
      wr(adr(3, 0), 32'h0);
      wr(adr(3, 1), 32'h0);
      chk("R5 zero clear no effect", pin_out, exp_out);
      // clear every odd pin
      for (int p = 1; p < NP; p += 2) begin
         wr(adr(3, p / 32), 32'(1) << (p % 32));
         exp_out[p] = 1'b0;
         chk("R5 clear sweep", pin_out, exp_out);
      end
      wr(adr(2, 1), 32'h0);
      chk("R5 zero set no effect", pin_out, exp_out);
      rd(adr(2, 0), rv); chk("R5 set reads 0", 64'(rv), 0);
      rd(adr(3, 1), rv); chk("R5 clear reads 0", 64'(rv), 0);

      // R6 writes elsewhere leave outputs alone; R2 unmapped and misaligned
      wr(adr(4, 0), 32'h0);
      chk("R6 out stable", pin_out, exp_out);
      chk("R6 oe stable", pin_oe, exp_oe);
      wr(adr(7, 0), 32'hFFFF_FFFF);
      wr(adr(1, 0) + 1, 32'hFFFF_FFFF);
      rd(adr(7, 0), rv); chk("R2 unmapped reads 0", 64'(rv), 0);
      rd(adr(1, 0) + 1, rv); chk("R2 misaligned reads 0", 64'(rv), 0);
      chk("R2 unmapped write ignored", pin_oe, exp_oe);

      // R3 level timing and read-only
      @(negedge clk);
      pin_in = 64'hDEAD_BEEF_0123_4567;
      rd(adr(0, 0), rv); chk("R3 not yet at E2", 64'(rv), 0);
      rd(adr(0, 0), rv); chk("R3 seen at E3", 64'(rv), 64'h0123_4567);
      rd(adr(0, 1), rv); chk("R3 upper word", 64'(rv), 64'hDEAD_BEEF);
      wr(adr(0, 1), 32'h0);
      rd(adr(0, 1), rv); chk("R3 write ignored", 64'(rv), 64'hDEAD_BEEF);
      // R11 hold while bus_rd low
      wr(adr(1, 0), 32'h0);
      exp_oe[31:0] = '0;
      repeat (2) @(negedge clk);
      chk("R11 rdata holds", 64'(bus_rdata), 64'hDEAD_BEEF);
      @(negedge clk);
      pin_in = '0;
      repeat (4) @(negedge clk);

      // R7 rising sweep across all pins, with R8 clear and R10 irq
      wr(adr(4, 0), 32'hFFFF_FFFF);
      wr(adr(4, 1), 32'hFFFF_FFFF);
      for (int p = 0; p < NP; p++) begin
         @(negedge clk);
         pin_in[p] = 1'b1;
         if (p == 0) begin
            @(posedge clk); #1; @(posedge clk); #1;
            chk("R10 irq low at E2", 64'(irq), 0);
            @(posedge clk); #1;
            chk("R10 irq high at E3", 64'(irq), 1);
         end else begin
            repeat (3) @(negedge clk);
            chk("R10 irq set", 64'(irq), 1);
         end
         for (int w = 0; w < WORDS; w++) begin
            rd(adr(6, w), rv);
            chk("R7 rising latch", 64'(rv),
                (w == p / 32) ? 64'(32'(1) << (p % 32)) : 64'd0);
         end
         wr(adr(6, p / 32), 32'(1) << (p % 32));
         chk("R8 cleared irq low", 64'(irq), 0);
         @(negedge clk);
         pin_in[p] = 1'b0;
         repeat (4) @(negedge clk);
         chk("R7 falling without enable", 64'(irq), 0);
      end
      wr(adr(4, 0), 32'h0);
      wr(adr(4, 1), 32'h0);

      // R7 falling only on pin 3
      wr(adr(5, 0), 32'h0000_0008);
      @(negedge clk); pin_in[3] = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 rise ignored when only falling", 64'(irq), 0);
      pin_in[3] = 1'b0;
      repeat (4) @(negedge clk);
      rd(adr(6, 0), rv); chk("R7 falling latch", 64'(rv), 64'h8);
      // R8 zero write and other-bit write keep it
      wr(adr(6, 0), 32'h0);
      rd(adr(6, 0), rv); chk("R8 zero write keeps", 64'(rv), 64'h8);
      wr(adr(6, 0), 32'h0000_0001);
      rd(adr(6, 0), rv); chk("R8 other bit keeps", 64'(rv), 64'h8);
      wr(adr(6, 0), 32'h8);
      wr(adr(5, 0), 32'h0);

      // R7 both enables on pin 40
      wr(adr(4, 1), 32'h100);
      wr(adr(5, 1), 32'h100);
      @(negedge clk); pin_in[40] = 1'b1;
      repeat (4) @(negedge clk);
      rd(adr(6, 1), rv); chk("R7 both rise", 64'(rv), 64'h100);
      wr(adr(6, 1), 32'h100);
      @(negedge clk); pin_in[40] = 1'b0;
      repeat (4) @(negedge clk);
      rd(adr(6, 1), rv); chk("R7 both fall", 64'(rv), 64'h100);
      wr(adr(6, 1), 32'h100);
      wr(adr(4, 1), 32'h0);
      wr(adr(5, 1), 32'h0);

      // R9 clear colliding with a new edge on pin 7
      wr(adr(4, 0), 32'h80);
      @(negedge clk); pin_in[7] = 1'b1;
      repeat (4) @(negedge clk);
      pin_in[7] = 1'b0;
      repeat (4) @(negedge clk);
      pin_in[7] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(adr(6, 0)); bus_wdata = 32'h80;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(adr(6, 0), rv); chk("R9 collision keeps bit", 64'(rv), 64'h80);
      chk("R9 irq stays", 64'(irq), 1);
      wr(adr(6, 0), 32'h80);
      rd(adr(6, 0), rv); chk("R8 plain clear", 64'(rv), 0);

      chk("R6 final out", pin_out, exp_out);
      chk("R4 final oe", pin_oe, exp_oe);
      finish_run();
   end
endmodule